// File: doc/BRIEF.md
# Receive Flow-Character and Special-Character Detector

This block sits between a UART's serial receiver and its receive FIFO. Every byte the receiver delivers is compared against four programmable character registers: two XON/XOFF pairs. The block then decides whether the byte goes into the FIFO or is consumed as a flow-control character. It also keeps a transmit-pause state that the transmitter honours, raises a one-cycle XOFF interrupt pulse, and maintains a special-character status flag.

A two-bit mode input picks which character pair, if any, acts as flow control. The special-character compare always uses the second XOFF register. When that register is also the active flow-control XOFF, the matching byte is consumed. When it is not, the byte is kept in the data stream. The special-character flag holds until the next received byte has been judged.

Top module: `rxchr_detect`

## Requirements
- R1: Every result for a byte received with `rx_valid` high appears on the cycle after that strobe. On a kept byte, `fifo_wr` is high for exactly one cycle and `fifo_wdata` carries the byte.
- R2: With `flow_mode` 2'b00 or 2'b11, every received byte is written to the FIFO, `xoff_irq` stays low and `tx_pause` does not change.
- R3: With `flow_mode` 2'b10, a byte equal to `xoff1_chr` is not written, sets `tx_pause` and pulses `xoff_irq`. A byte equal to `xon1_chr` is not written and clears `tx_pause`.
- R4: With `flow_mode` 2'b10, a byte equal to `xoff2_chr` that is not a pair-1 flow character is written to the FIFO, even when special detection is on.
- R5: With `flow_mode` 2'b01, a byte equal to `xoff2_chr` is not written, sets `tx_pause` and pulses `xoff_irq`.
- R6: With `flow_mode` 2'b01, a byte equal to `xon2_chr` is not written and clears `tx_pause`.
- R7: `spec_flag` is set by a byte equal to `xoff2_chr` only when both `spec_en` and `spec_ie` are 1. The compare is bit-exact, with bit 0 of the register matching bit 0 of the byte.
- R8: `spec_flag` changes only on the cycle after a received byte. It clears when that byte is not a qualifying special match, and it holds while no byte arrives.
- R9: After reset, `fifo_wr`, `spec_flag`, `xoff_irq` and `tx_pause` are 0.
- R10: When a byte equals both the XOFF and the XON of the selected pair, the XOFF action wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_data` |
| spec_en | input | 1 | Special-character detect enable |
| flow_mode | input | 2 | 00/11 no flow matching, 10 pair 1, 01 pair 2 |
| spec_ie | input | 1 | Special-character interrupt enable |
| xon1_chr | input | 8 | Pair 1 resume character |
| xoff1_chr | input | 8 | Pair 1 pause character |
| xon2_chr | input | 8 | Pair 2 resume character |
| xoff2_chr | input | 8 | Pair 2 pause character, also the special character |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | Byte to write |
| spec_flag | output | 1 | Special-character status flag |
| xoff_irq | output | 1 | One-cycle pulse on a received active XOFF |
| tx_pause | output | 1 | Transmitter must hold off while high |

## Verification
A wrong pause state stays hidden until the transmitter is supposed to resume or stop. It therefore shows on `tx_pause` one cycle after the XON or XOFF byte that should have changed it, and it persists until the next flow character. A wrong keep/consume decision shows as a missing or extra `fifo_wr` pulse one cycle after the byte. A wrong flag shows on `spec_flag` at the same point and lingers until the next byte. A behavioural model in the bench compares all outputs on every cycle, so each of these faults is reported in the first cycle in which it is visible.

// File: rtl/rxchr_pkg.sv
// Shared types for the receive character detector.
// Assumes byte-wide characters and four compare registers in a fixed index order.
package rxchr_pkg;
    localparam int NUM_CMP  = 4;
    localparam int IDX_XON1  = 0;
    localparam int IDX_XOFF1 = 1;
    localparam int IDX_XON2  = 2;
    localparam int IDX_XOFF2 = 3;

    typedef enum logic [1:0] {
        FLOW_OFF   = 2'b00,
        FLOW_PAIR2 = 2'b01,
        FLOW_PAIR1 = 2'b10,
        FLOW_OFF_B = 2'b11
    } flow_mode_e;

    typedef struct packed {
        logic keep;
        logic spec;
        logic xoff;
        logic xon;
    } rx_decision_t;
endpackage

// File: rtl/rxchr_cmp_bank.sv
// Equality comparator bank: one match bit per programmable character.
// Assumes registers are packed with index 0 in the low bits.
module rxchr_cmp_bank #(
    parameter int DATA_W = 8,
    parameter int N_CMP  = 4
) (
    input  logic [N_CMP-1:0][DATA_W-1:0] cmp_vals,
    input  logic [DATA_W-1:0]            data,
    output logic [N_CMP-1:0]             match
);
    for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
        // Bitwise equality, bit 0 of the register against bit 0 of the byte.
        assign match[gi] = (cmp_vals[gi] == data);
    end
endmodule

// File: rtl/rxchr_decide.sv
// Combinational keep/consume decision for one received byte.
// Assumes match bits follow the index order of rxchr_pkg.
module rxchr_decide
    import rxchr_pkg::*;
(
    input  logic [NUM_CMP-1:0] match,
    input  flow_mode_e         mode,
    input  logic               spec_en,
    input  logic               spec_ie,
    output rx_decision_t       dec
);
    logic hit_off;
    logic hit_on;

    // Select the flow-control pair named by the mode.
    always_comb begin
        hit_off = 1'b0;
        hit_on  = 1'b0;
        case (mode)
            FLOW_PAIR1: begin
                hit_off = match[IDX_XOFF1];
                hit_on  = match[IDX_XON1];
            end
            FLOW_PAIR2: begin
                hit_off = match[IDX_XOFF2];
                hit_on  = match[IDX_XON2];
            end
            default: begin
                hit_off = 1'b0;
                hit_on  = 1'b0;
            end
        endcase
    end

    // Build the decision; XOFF takes priority over XON.
    always_comb begin
        dec.xoff = hit_off;
        dec.xon  = hit_on & ~hit_off;
        dec.keep = ~(hit_off | hit_on);
        dec.spec = spec_en & spec_ie & match[IDX_XOFF2];
    end
endmodule

// File: rtl/rxchr_state.sv
// Output registers: FIFO strobe, data, interrupt pulse, pause and flag.
// Assumes rx_valid is qualified for one cycle per byte.
module rxchr_state
    import rxchr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  rx_decision_t      dec,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              spec_flag,
    output logic              xoff_irq,
    output logic              tx_pause
);
    // Per-byte strobes, valid only on the cycle after the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
            xoff_irq   <= 1'b0;
        end else begin
            fifo_wr  <= rx_valid & dec.keep;
            xoff_irq <= rx_valid & dec.xoff;
            if (rx_valid) fifo_wdata <= rx_data;
        end
    end

    // Sticky state, updated only when a byte is judged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_flag <= 1'b0;
            tx_pause  <= 1'b0;
        end else if (rx_valid) begin
            spec_flag <= dec.spec;
            if (dec.xoff)     tx_pause <= 1'b1;
            else if (dec.xon) tx_pause <= 1'b0;
        end
    end
endmodule

// File: rtl/rxchr_detect.sv
// Top: receive flow-character and special-character detector.
// Assumes the register inputs are quasi-static relative to received bytes.
module rxchr_detect
    import rxchr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              spec_en,
    input  logic [1:0]        flow_mode,
    input  logic              spec_ie,
    input  logic [DATA_W-1:0] xon1_chr,
    input  logic [DATA_W-1:0] xoff1_chr,
    input  logic [DATA_W-1:0] xon2_chr,
    input  logic [DATA_W-1:0] xoff2_chr,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              spec_flag,
    output logic              xoff_irq,
    output logic              tx_pause
);
    logic [NUM_CMP-1:0][DATA_W-1:0] cmp_vals;
    logic [NUM_CMP-1:0]             match;
    rx_decision_t                   dec;

    // Pack the character registers in package index order.
    assign cmp_vals = {xoff2_chr, xon2_chr, xoff1_chr, xon1_chr};

    rxchr_cmp_bank #(.DATA_W(DATA_W), .N_CMP(NUM_CMP)) u_cmp (
        .cmp_vals (cmp_vals),
        .data     (rx_data),
        .match    (match)
    );

    rxchr_decide u_dec (
        .match   (match),
        .mode    (flow_mode_e'(flow_mode)),
        .spec_en (spec_en),
        .spec_ie (spec_ie),
        .dec     (dec)
    );

    rxchr_state #(.DATA_W(DATA_W)) u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .dec        (dec),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .spec_flag  (spec_flag),
        .xoff_irq   (xoff_irq),
        .tx_pause   (tx_pause)
    );
endmodule

// File: rtl/rxchr_detect_chk.sv
// Port-level checker for rxchr_detect, attached with bind.
module rxchr_detect_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              spec_en,
    input logic [1:0]        flow_mode,
    input logic              spec_ie,
    input logic [DATA_W-1:0] xoff2_chr,
    input logic              fifo_wr,
    input logic              spec_flag,
    input logic              xoff_irq,
    input logic              tx_pause
);
    AST_WR_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n) fifo_wr |-> $past(rx_valid)); // R1
    AST_OFF_ALL_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && (flow_mode == 2'b00 || flow_mode == 2'b11)) |=> (fifo_wr && !xoff_irq)); // R2
    AST_XOFF_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n) xoff_irq |-> (!fifo_wr && tx_pause)); // R3
    AST_SPEC_KEPT_PAIR1: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && flow_mode == 2'b10 && spec_en && rx_data == xoff2_chr) |=> (fifo_wr || xoff_irq || !tx_pause)); // R4
    AST_SPEC_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n) $rose(spec_flag) |-> ($past(spec_ie) && $past(spec_en))); // R7
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid |=> $stable(spec_flag)); // R8
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid |=> ($stable(tx_pause) && !fifo_wr && !xoff_irq)); // R1
endmodule

bind rxchr_detect rxchr_detect_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .spec_en   (spec_en),
    .flow_mode (flow_mode),
    .spec_ie   (spec_ie),
    .xoff2_chr (xoff2_chr),
    .fifo_wr   (fifo_wr),
    .spec_flag (spec_flag),
    .xoff_irq  (xoff_irq),
    .tx_pause  (tx_pause)
);

// File: tb/rxchr_detect_tb_top.sv
module rxchr_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       spec_en = 1'b0;
    logic [1:0] flow_mode = 2'b00;
    logic       spec_ie = 1'b0;
    logic [7:0] xon1_chr = 8'h11, xoff1_chr = 8'h13, xon2_chr = 8'hA5, xoff2_chr = 8'h1E;
    logic       fifo_wr, spec_flag, xoff_irq, tx_pause;
    logic [7:0] fifo_wdata;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R9";

    // Reference model state
    logic       e_wr = 0, e_spec = 0, e_irq = 0, e_pause = 0;
    logic [7:0] e_data = 0;
    logic [7:0] kept_q[$];

    always #10 clk = ~clk;

    rxchr_detect dut_i (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .spec_en(spec_en), .flow_mode(flow_mode), .spec_ie(spec_ie),
        .xon1_chr(xon1_chr), .xoff1_chr(xoff1_chr), .xon2_chr(xon2_chr), .xoff2_chr(xoff2_chr),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .spec_flag(spec_flag),
        .xoff_irq(xoff_irq), .tx_pause(tx_pause)
    );

    // Behavioural reference: decide what the block must show one cycle later.
    always @(posedge clk) begin
        bit is_off, is_on;
        e_wr  = 0;
        e_irq = 0;
        if (!rst_n) begin
            e_spec = 0; e_pause = 0; kept_q.delete();
        end else if (rx_valid) begin
            is_off = 0; is_on = 0;
            if (flow_mode == 2'b10) begin
                is_off = (rx_data == xoff1_chr); is_on = (rx_data == xon1_chr);
            end else if (flow_mode == 2'b01) begin
                is_off = (rx_data == xoff2_chr); is_on = (rx_data == xon2_chr);
            end
            if (is_off) begin
                e_pause = 1; e_irq = 1;
            end else if (is_on) begin
                e_pause = 0;
            end else begin
                e_wr = 1; kept_q.push_back(rx_data);
            end
            e_spec = spec_en && spec_ie && (rx_data == xoff2_chr);
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Compare every cycle, 5 ns after the rising edge.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            check("fifo_wr", fifo_wr, e_wr);
            check("xoff_irq", xoff_irq, e_irq);
            check("tx_pause", tx_pause, e_pause);
            check("spec_flag", spec_flag, e_spec);
            if (e_wr && kept_q.size() > 0) begin
                e_data = kept_q.pop_front();
                check("fifo_wdata", fifo_wdata, e_data);
            end
        end
    end

    task automatic send(logic [7:0] b, int gap);
        @(negedge clk);
        rx_data = b; rx_valid = 1;
        @(negedge clk);
        rx_valid = 0;
        for (int i = 0; i < gap; i++) @(negedge clk);
    endtask

    task automatic run_main;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 fifo_wr", fifo_wr, 0);
        check("R9 spec_flag", spec_flag, 0);
        check("R9 xoff_irq", xoff_irq, 0);
        check("R9 tx_pause", tx_pause, 0);
        rst_n = 1;
        @(negedge clk);

        cur_req = "R2"; flow_mode = 2'b00;
        send(8'h13, 0); send(8'h11, 1); send(8'hA5, 0); send(8'h1E, 2);
        flow_mode = 2'b11;
        send(8'h13, 0); send(8'h1E, 2);

        cur_req = "R3"; flow_mode = 2'b10;
        send(8'h41, 0); send(8'h13, 2); send(8'h42, 0); send(8'h11, 2);
        @(negedge clk); check("R3 pause released", tx_pause, 0);

        cur_req = "R4"; spec_en = 1; spec_ie = 1;
        send(8'h1E, 2);
        check("R4 flag set on kept special", spec_flag, 1);

        cur_req = "R8";
        repeat (4) @(negedge clk);
        check("R8 flag holds while idle", spec_flag, 1);
        send(8'h55, 1);
        check("R8 flag cleared by next byte", spec_flag, 0);

        cur_req = "R7"; spec_ie = 0;
        send(8'h1E, 1);
        check("R7 no flag without enable", spec_flag, 0);
        spec_ie = 1;
        send(8'h78, 1);
        check("R7 reversed bits no match", spec_flag, 0);
        spec_en = 0;
        send(8'h1E, 1);
        spec_en = 1;

        cur_req = "R5"; flow_mode = 2'b01;
        send(8'h1E, 1);
        check("R5 pause", tx_pause, 1);
        check("R5 flag", spec_flag, 1);
        spec_en = 0;
        send(8'h1E, 1);

        cur_req = "R6";
        send(8'hA5, 1);
        check("R6 pause cleared", tx_pause, 0);

        cur_req = "R10"; xon2_chr = 8'h1E;
        send(8'h1E, 1);
        check("R10 xoff wins", tx_pause, 1);
        xon2_chr = 8'hA5;
        send(8'hA5, 1);

        cur_req = "R1";
        for (int i = 0; i < 300; i++) begin
            logic [7:0] pick[6];
            pick = '{8'h11, 8'h13, 8'hA5, 8'h1E, 8'h00, 8'hFF};
            flow_mode = 2'($urandom_range(0, 3));
            spec_en = 1'($urandom_range(0, 1));
            spec_ie = 1'($urandom_range(0, 1));
            send(pick[$urandom_range(0, 5)], $urandom_range(0, 2));
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (20000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule